// File: doc/BRIEF.md
# Self-Refreshing Pseudo-Static DRAM Slave Model

This block is a synthesizable device-side model of a pseudo-static memory. The array inside is dynamic and needs periodic refresh, but the host never has to manage refresh. The host reaches the memory over a byte-wide double-data-rate bus with an active-low chip select. The model folds the two byte slots of each bus clock into one 16-bit word per internal clock. The upper byte is the first (rising-edge) slot and the lower byte is the second (falling-edge) slot. `rwds_o[1]` and `rwds_o[0]` are the strobe levels in those two slots. The byte-mask input `wmask_i` is arranged the same way.

Each transaction opens with three command/address words. These words select read or write, memory array or configuration register, wrapped or linear burst, and a start word. The model then waits out an initial latency and moves one data word per clock until chip select rises. A free-running timer raises a refresh request. The refresh runs only while chip select is high. While the command/address words arrive, the data strobe reports whether a refresh is outstanding. When it is, the latency doubles so that the refresh can be absorbed. A single configuration register holds the latency count.

Top module: `psram_model`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dq_valid_o` is 0 and `rwds_o` is 2'b00. The latency register resets to `LAT_DEFAULT` (3), and no refresh is pending or running.
- R2: A transaction starts at the first clock edge that samples `cs_n_i` low. An edge that samples `cs_n_i` high ends the transaction at any point, including during the command words. That edge returns the model to idle, clears `dq_valid_o` and `rwds_o`, and writes nothing. The next low sample starts a fresh command phase.
- R3: The three words sampled at the first three edges are CA0, CA1 and CA2. CA0 bit 15 set means read, bit 14 set means register space, and bit 13 set means linear burst. With the default 64-word array, the start word is {CA1[2:0], CA2[2:0]}. All other command bits are ignored.
- R4: From the edge that samples CA0 up to the edge that samples CA2, both bits of `rwds_o` equal the refresh flag. At the CA2 edge both bits return to 0.
- R5: Call the CA0 edge E0. The latency is L = cfg, or L = 2*cfg when the flag was set. Data word k occupies the cycle that ends at edge E(3+L+k). Write data is sampled at that edge. Read data is presented during that cycle. `dq_valid_o` stays 0 throughout the latency.
- R6: During each read data cycle, `dq_valid_o` is 1, `rwds_o` is 2'b10 (the strobe toggles once per word) and `dq_o` holds the addressed word. Outside the command phase and read data, `rwds_o` is 2'b00.
- R7: On memory writes, `wmask_i[1]`=1 leaves the high byte unchanged and `wmask_i[0]`=1 leaves the low byte unchanged. A mask bit of 0 writes that byte.
- R8: A linear burst advances by one word per data cycle and wraps from the last array word to word 0.
- R9: A wrapped burst stays inside its aligned group of 8 words. After the top word of the group it continues at the group base.
- R10: A register-space write loads `cfg` from data bits [3:0] and ignores the mask. A value of 0 is ignored. The memory array is not touched. A register-space read returns {12'b0, cfg}. A new value applies from the next transaction.
- R11: The refresh flag is set every `REF_INTERVAL` cycles. A pending refresh starts at an edge that samples `cs_n_i` high, then runs for `REF_CYCLES` cycles. The flag reported at CA0 is "pending or running".
- R12: A refresh request raised during an open transaction is held until chip select rises. It is not performed during the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; one bus clock with two byte slots |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select |
| dq_i | input | 16 | Command/address or write data word, first slot in [15:8] |
| wmask_i | input | 2 | Write byte mask per slot, 1 = keep the byte |
| dq_o | output | 16 | Read data word |
| dq_valid_o | output | 1 | Read data word present on `dq_o` |
| rwds_o | output | 2 | Strobe level per slot: refresh flag during the command phase, toggle during reads |

## Verification
The hardest case to reach is a refresh request that arrives while a transaction is open and must be deferred. From the ports this is visible only as a raised flag on the very next transaction. The bench overrides the refresh interval to a known value and counts cycles from reset. It opens a long linear read burst just before the request falls due and keeps it open well past that point. It then starts the next transaction after one idle cycle. There it expects the flag and a doubled latency. After a longer idle gap it expects a clear flag.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int WORD_W = 16;
  localparam int LANES  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CA,
    ST_LAT,
    ST_DATA
  } st_e;

  typedef struct packed {
    logic rd;
    logic regsp;
    logic lin;
  } cmd_t;
endpackage

// File: rtl/psram_refresh.sv
module psram_refresh #(
  parameter int INTERVAL = 400,
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_i,
  output logic flag_o
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] tick_q;
  logic [BW-1:0] left_q;
  logic          pend_q;
  logic          busy_q;
  logic          wrap;
  logic          start;

  assign wrap  = (tick_q == CW'(INTERVAL - 1));
  assign start = pend_q && !busy_q && idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      left_q <= '0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      tick_q <= wrap ? '0 : tick_q + 1'b1;
      if (wrap)       pend_q <= 1'b1;
      else if (start) pend_q <= 1'b0;
      if (busy_q) begin
        if (left_q == '0) busy_q <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end else if (start) begin
        busy_q <= 1'b1;
        left_q <= BW'(BUSY_CYC - 1);
      end
    end
  end

  assign flag_o = pend_q | busy_q;

  // R12: a refresh only begins after an idle (chip select high) sample
  a_r12_start_only_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(idle_i));

  // R11: a running refresh always ends within its length
  a_r11_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q == '0) |=> !busy_q);
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int AW = 6
) (
  input  logic                           clk,
  input  logic                           re_i,
  input  logic [AW-1:0]                  raddr_i,
  input  logic [psram_pkg::LANES-1:0]    we_i,
  input  logic [AW-1:0]                  waddr_i,
  input  logic [psram_pkg::WORD_W-1:0]   wdata_i,
  output logic [psram_pkg::WORD_W-1:0]   rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int BYTE_W = psram_pkg::WORD_W / psram_pkg::LANES;

  for (genvar g = 0; g < psram_pkg::LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[BYTE_W*g +: BYTE_W];
      if (re_i)    q <= mem[raddr_i];
    end
    assign rdata_o[BYTE_W*g +: BYTE_W] = q;
  end
endmodule

// File: rtl/psram_model.sv
module psram_model #(
  parameter int AW           = 6,
  parameter int WRAP_W       = 3,
  parameter int LAT_W        = 4,
  parameter int LAT_DEFAULT  = 3,
  parameter int REF_INTERVAL = 400,
  parameter int REF_CYCLES   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n_i,
  input  logic [15:0] dq_i,
  input  logic [1:0]  wmask_i,
  output logic [15:0] dq_o,
  output logic        dq_valid_o,
  output logic [1:0]  rwds_o
);
  import psram_pkg::*;

  localparam int RW = AW - 3;
  localparam logic [AW-1:0] WMASK = AW'((1 << WRAP_W) - 1);

  st_e            st_q;
  cmd_t           cmd_q;
  logic           second_q;
  logic [RW-1:0]  row_q;
  logic [AW-1:0]  addr_q;
  logic [LAT_W:0] lat_q;
  logic           flag_q;
  logic [LAT_W-1:0] cfg_q;
  logic           valid_q;
  logic [1:0]     rwds_q;
  logic           regsel_q;

  logic           ref_flag;
  logic           fetch, wr, cfg_we;
  logic [AW-1:0]  nxt_addr;
  logic [1:0]     ram_we;
  logic [15:0]    ram_q;

  psram_refresh #(.INTERVAL(REF_INTERVAL), .BUSY_CYC(REF_CYCLES)) u_ref (
    .clk(clk), .rst(rst), .idle_i(cs_n_i), .flag_o(ref_flag)
  );

  always_comb begin
    nxt_addr = cmd_q.lin ? addr_q + 1'b1
                         : (addr_q & ~WMASK) | ((addr_q + 1'b1) & WMASK);
    fetch = !cs_n_i && cmd_q.rd &&
            ((st_q == ST_LAT && lat_q == (LAT_W+1)'(1)) || st_q == ST_DATA);
    wr     = !cs_n_i && !cmd_q.rd && st_q == ST_DATA;
    ram_we = {2{wr && !cmd_q.regsp}} & ~wmask_i;
    cfg_we = wr && cmd_q.regsp && (dq_i[LAT_W-1:0] != '0);
  end

  psram_array #(.AW(AW)) u_mem (
    .clk(clk), .re_i(fetch && !cmd_q.regsp), .raddr_i(addr_q),
    .we_i(ram_we), .waddr_i(addr_q), .wdata_i(dq_i), .rdata_o(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cmd_q    <= '0;
      second_q <= 1'b0;
      row_q    <= '0;
      addr_q   <= '0;
      lat_q    <= '0;
      flag_q   <= 1'b0;
      cfg_q    <= LAT_W'(LAT_DEFAULT);
      valid_q  <= 1'b0;
      rwds_q   <= 2'b00;
      regsel_q <= 1'b0;
    end else if (cs_n_i) begin
      st_q    <= ST_IDLE;
      valid_q <= 1'b0;
      rwds_q  <= 2'b00;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cmd_q    <= dq_i[15:13];
          flag_q   <= ref_flag;
          rwds_q   <= {2{ref_flag}};
          second_q <= 1'b0;
          st_q     <= ST_CA;
        end
        ST_CA: begin
          if (!second_q) begin
            row_q    <= dq_i[RW-1:0];
            second_q <= 1'b1;
          end else begin
            addr_q <= {row_q, dq_i[2:0]};
            lat_q  <= flag_q ? {cfg_q, 1'b0} : {1'b0, cfg_q};
            rwds_q <= 2'b00;
            st_q   <= ST_LAT;
          end
        end
        ST_LAT: begin
          if (lat_q == (LAT_W+1)'(1)) begin
            st_q     <= ST_DATA;
            regsel_q <= cmd_q.regsp;
            if (cmd_q.rd) begin
              valid_q <= 1'b1;
              rwds_q  <= 2'b10;
              addr_q  <= nxt_addr;
            end
          end else begin
            lat_q <= lat_q - 1'b1;
          end
        end
        default: begin
          addr_q <= nxt_addr;
          if (cfg_we) cfg_q <= dq_i[LAT_W-1:0];
        end
      endcase
    end
  end

  assign dq_o       = regsel_q ? {{(16-LAT_W){1'b0}}, cfg_q} : ram_q;
  assign dq_valid_o = valid_q;
  assign rwds_o     = rwds_q;

  // R6: read data always travels with a toggling strobe
  a_r6_strobe_with_data: assert property (@(posedge clk) disable iff (rst)
    dq_valid_o |-> rwds_o == 2'b10);
  // R2: data is only presented after a chip-select-low sample
  a_r2_valid_needs_cs: assert property (@(posedge clk) disable iff (rst)
    dq_valid_o |-> !$past(cs_n_i));
  // R4: both slots carry the same flag during the command words
  a_r4_ca_flag_level: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CA) |-> rwds_o[1] == rwds_o[0]);
  // R5: nothing is presented before the data phase
  a_r5_quiet_latency: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_DATA) |-> !dq_valid_o);
  // R10: the latency count never becomes zero
  a_r10_lat_nonzero: assert property (@(posedge clk) disable iff (rst)
    cfg_q != '0);
endmodule

// File: tb/psram_model_tb.sv
`timescale 1ns/1ps
module psram_model_tb;
  localparam int DEPTH = 64;
  localparam int NV = 9;

  typedef struct packed {
    logic       rd;
    logic       lin;
    logic [7:0] addr;
    logic [7:0] n;
    logic [1:0] mask;
    logic [15:0] base;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'd0,  8'd64, 2'b00, 16'h1000},  // R8 fill whole array
    '{1'b1, 1'b1, 8'd0,  8'd8,  2'b00, 16'h0000},  // R6 linear read
    '{1'b0, 1'b0, 8'd13, 8'd6,  2'b00, 16'h2200},  // R9 wrapped write
    '{1'b1, 1'b0, 8'd14, 8'd8,  2'b00, 16'h0000},  // R9 wrapped read
    '{1'b0, 1'b1, 8'd62, 8'd4,  2'b10, 16'h3300},  // R7 R8 keep high byte, wrap end
    '{1'b0, 1'b1, 8'd1,  8'd2,  2'b01, 16'h4400},  // R7 keep low byte
    '{1'b1, 1'b1, 8'd60, 8'd8,  2'b00, 16'h0000},  // R8 read across end
    '{1'b0, 1'b1, 8'd3,  8'd1,  2'b11, 16'h5500},  // R7 both masked
    '{1'b1, 1'b0, 8'd0,  8'd10, 2'b00, 16'h0000}   // R3 R9 wrap group 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic [15:0] dq = '0;
  logic [1:0]  wmask = '0;
  logic [15:0] dq_o;
  logic        valid;
  logic [1:0]  rwds;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cur_lat = 3;
  logic [15:0] ref_mem [DEPTH];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  psram_model #(.REF_INTERVAL(1000), .REF_CYCLES(4)) u_dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .dq_i(dq), .wmask_i(wmask),
    .dq_o(dq_o), .dq_valid_o(valid), .rwds_o(rwds)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int a, input bit lin);
    return lin ? (a + 1) % DEPTH : (a & ~7) | ((a + 1) & 7);
  endfunction

  task automatic txn(input bit rd, input bit rs, input bit lin, input int addr, input int n,
                     input logic [15:0] base, input logic [1:0] mask, input bit ef);
    int L = cur_lat * (ef ? 2 : 1);
    int a = addr;
    int new_lat = cur_lat;
    logic [15:0] w;
    logic [15:0] e;
    logic [5:0] ab = 6'(addr);
    @(negedge clk); cs_n = 1'b0; dq = {rd, rs, lin, 13'h0000};
    @(negedge clk);
    chk(rwds == {ef, ef}, "R4/R11/R12 flag on CA1", 32'(rwds), 32'({ef, ef}));
    dq = {13'h1ABC, ab[5:3]};
    @(negedge clk);
    chk(rwds == {ef, ef}, "R4/R11/R12 flag on CA2", 32'(rwds), 32'({ef, ef}));
    dq = {13'h0F0F, ab[2:0]};
    for (int j = 0; j < L; j++) begin
      @(negedge clk);
      if (j == 0) chk(rwds == 2'b00, "R4 flag dropped after CA", 32'(rwds), 0);
      chk(!valid, "R5 no data during latency", 32'(valid), 0);
      dq = '0;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      w = base + 16'(k) * 16'h0101;
      if (rd) begin
        e = rs ? 16'(cur_lat) : ref_mem[a];
        chk(valid && rwds == 2'b10, "R5/R6 valid and strobe", {30'(valid), rwds}, 32'h6);
        chk(dq_o == e, "R3/R6/R8/R9/R10 read word", 32'(dq_o), 32'(e));
      end else begin
        dq = w;
        wmask = mask;
        if (rs) begin
          if (w[3:0] != 4'h0) new_lat = int'(w[3:0]);
        end else begin
          if (!mask[1]) ref_mem[a][15:8] = w[15:8];
          if (!mask[0]) ref_mem[a][7:0]  = w[7:0];
        end
      end
      a = nxt(a, lin);
    end
    @(negedge clk); cs_n = 1'b1; dq = 16'hDEAD; wmask = 2'b00;
    @(negedge clk);
    chk(!valid && rwds == 2'b00, "R2 idle after CS high", {30'(valid), rwds}, 0);
    cur_lat = new_lat;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid && rwds == 2'b00, "R1 outputs in reset", {30'(valid), rwds}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!valid && rwds == 2'b00, "R1 outputs after reset", {30'(valid), rwds}, 0);
    txn(1'b1, 1'b1, 1'b1, 0, 1, 16'h0, 2'b00, 1'b0);  // R1 reset latency reads back as 3

    for (int i = 0; i < NV; i++)
      txn(VECS[i].rd, 1'b0, VECS[i].lin, int'(VECS[i].addr), int'(VECS[i].n),
          VECS[i].base, VECS[i].mask, 1'b0);

    // R10: register write with full mask still applies; new latency on next access
    txn(1'b0, 1'b1, 1'b1, 0, 1, 16'h0005, 2'b11, 1'b0);
    txn(1'b1, 1'b0, 1'b1, 0, 2, 16'h0, 2'b00, 1'b0);
    txn(1'b1, 1'b1, 1'b1, 0, 1, 16'h0, 2'b00, 1'b0);
    txn(1'b0, 1'b1, 1'b1, 0, 1, 16'hFFF0, 2'b00, 1'b0);  // R10 zero ignored
    txn(1'b1, 1'b1, 1'b1, 0, 1, 16'h0, 2'b00, 1'b0);
    txn(1'b0, 1'b1, 1'b1, 0, 1, 16'h0003, 2'b00, 1'b0);
    txn(1'b1, 1'b0, 1'b1, 8, 8, 16'h0, 2'b00, 1'b0);     // R10 memory untouched

    // R2: abort during command words, then a normal access
    @(negedge clk); cs_n = 1'b0; dq = 16'h2000;
    @(negedge clk); dq = 16'h0007;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk(!valid && rwds == 2'b00, "R2 abort in CA", {30'(valid), rwds}, 0);
    txn(1'b1, 1'b0, 1'b1, 5, 2, 16'h0, 2'b00, 1'b0);

    // R2: write burst ended after two words leaves the third word alone
    txn(1'b0, 1'b0, 1'b1, 20, 2, 16'h7700, 2'b00, 1'b0);
    txn(1'b1, 1'b0, 1'b1, 20, 3, 16'h0, 2'b00, 1'b0);

    // R11/R12: burst held open across the refresh request
    while (cyc < 950) @(negedge clk);
    txn(1'b1, 1'b0, 1'b1, 0, 100, 16'h0, 2'b00, 1'b0);
    txn(1'b1, 1'b0, 1'b1, 5, 2, 16'h0, 2'b00, 1'b1);
    repeat (8) @(negedge clk);
    txn(1'b1, 1'b0, 1'b0, 9, 3, 16'h0, 2'b00, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule